// File: doc/BRIEF.md
# Four-Way Set-Associative Write-Through Data Cache

This block is a 2-Kbyte data cache placed between a 32-bit processor port and a one-word-wide main-memory port. The storage is 16 sets. Each set holds four ways, and each way holds one 32-byte block of eight words. A request is latched in one cycle. In the next cycle the four tags of the addressed set are compared at the same time, and on a match the word from the matching way is steered to the processor.

A read that misses picks a victim way and refills the whole block one word at a time from a main memory built of four interleaved banks. The victim is an invalid way if the set has one, and otherwise the true least-recently-used way. The miss completes once the block is resident. Every store is sent on to main memory. A store that hits also updates the cached word. A store that misses leaves the cache untouched. The processor is held until memory acknowledges the store.

The controller has five states, held in a register and selected by a `unique case`:

| State | What happens in it |
|---|---|
| ST_IDLE | Waits for a request. |
| ST_TAG | Compares the tags of the addressed set. |
| ST_FILL | Refills the block, one word per memory acknowledge. |
| ST_WRITE | Waits for memory to acknowledge a store. |
| ST_DONE | Returns the word that was just refilled. |

Its transitions are:

| Transition | Condition |
|---|---|
| ST_IDLE → ST_TAG | `cpu_req` is high. |
| ST_TAG → ST_IDLE | Read hit. |
| ST_TAG → ST_FILL | Read miss. |
| ST_TAG → ST_WRITE | Any store. |
| ST_FILL → ST_DONE | Acknowledge of word 7. |
| ST_DONE → ST_IDLE | Always, one cycle later. |
| ST_WRITE → ST_IDLE | Store acknowledge. |

Top module: `cache_wt4`

## Requirements
- R1: A synchronous reset clears every valid bit. The first read of any address after reset is therefore a miss, and it returns the word held in main memory.
- R2: A read hit returns the cached word with `cpu_ready` high in the first cycle after the request is latched, which is a latency of one clock. At most one way matches.
- R3: The refill sequence is fixed:
  - A read miss fetches words 0 to 7 of the block in ascending order, at byte addresses base+4·i.
  - `mem_bank` equals i mod 4, which is address bits [3:2].
  - `cpu_ready` rises only after the eighth word has been stored and the block made valid.
  - With a memory that acknowledges each request one cycle after it appears, a miss takes 18 clocks.
- R4: The address is split as follows:
  - byte offset [1:0]
  - word select [4:2]
  - set index [8:5]
  - tag [31:9]
  
  Blocks in different sets never displace each other.
- R5: Every store produces exactly one main-memory write carrying the store's word address and data. `cpu_ready` for a store rises only in the cycle `mem_ack` arrives, which gives a store latency of 3 clocks with the memory described above.
- R6: A store that hits updates the cached word. A later read of that word hits and returns the new data.
- R7: A store that misses leaves the cache unchanged. A later read of that address misses and returns the stored data from memory.
- R8: A refill always uses an invalid way of the set when one exists. Four blocks with distinct tags in one set are therefore all resident together.
- R9: Replacement is true LRU. Every hit and every completed refill makes the touched way the most recent in its set. When all four ways are valid, a miss evicts the way touched longest ago.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_req | input | 1 | Processor request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Processor byte address |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data, valid while `cpu_ready` is high |
| cpu_ready | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Main-memory request |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | 32 | Word-aligned memory byte address |
| mem_bank | output | 2 | Interleaved bank addressed (`mem_addr[3:2]`) |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ack` |
| mem_ack | input | 1 | Memory completion for the current request |

## Verification
The lookup is tried with several access patterns:

- A cold read shows that reset leaves nothing valid and exposes the refill order and bank sequence.
- A second word of the same block separates word selection from set selection.
- Store hits and store misses separate the update of the cached word from the write-through that happens in both cases.
- Four tags loaded into one set, then a fifth, together with a touch order chosen so that the least-recent way differs from the earliest-filled way, separate true LRU from simple fill order.
- A block in another set, read again at the end, shows that the sets are independent.

// File: rtl/cache_wt_pkg.sv
package cache_wt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TAG,
        ST_FILL,
        ST_WRITE,
        ST_DONE
    } cache_state_e;

endpackage

// File: rtl/cache_tag_match.sv
module cache_tag_match #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 23,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmp_en,
    input  logic [TAG_W-1:0] way_tag [WAYS],
    input  logic [WAYS-1:0]  way_valid,
    input  logic [TAG_W-1:0] req_tag,
    output logic [WAYS-1:0]  hit_vec,
    output logic             hit,
    output logic [WAY_W-1:0] hit_way
);

    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            hit_vec[w] = way_valid[w] && (way_tag[w] == req_tag);
        end
    end

    always_comb begin
        hit     = 1'b0;
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (hit_vec[w] && !hit) begin
                hit     = 1'b1;
                hit_way = WAY_W'(w);
            end
        end
    end

    // R2
    onehot_hit_chk: assert property (@(posedge clk) disable iff (rst)
        cmp_en |-> $onehot0(hit_vec));

endmodule

// File: rtl/cache_lru.sv
module cache_lru #(
    parameter int WAYS = 4,
    parameter int SETS = 16,
    localparam int WAY_W = $clog2(WAYS),
    localparam int SET_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             touch_en,
    input  logic [SET_W-1:0] touch_set,
    input  logic [WAY_W-1:0] touch_way,
    input  logic [SET_W-1:0] query_set,
    input  logic [WAYS-1:0]  query_valid,
    output logic [WAY_W-1:0] victim_way
);

    // rank 0 = most recent, WAYS-1 = least recent
    logic [WAY_W-1:0] rank_q [SETS][WAYS];
    logic             found;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    rank_q[s][w] <= WAY_W'(w);
                end
            end
        end else if (touch_en) begin
            for (int w = 0; w < WAYS; w++) begin
                if (WAY_W'(w) == touch_way) begin
                    rank_q[touch_set][w] <= '0;
                end else if (rank_q[touch_set][w] < rank_q[touch_set][touch_way]) begin
                    rank_q[touch_set][w] <= rank_q[touch_set][w] + 1'b1;
                end
            end
        end
    end

    always_comb begin
        victim_way = '0;
        found      = 1'b0;
        for (int w = 0; w < WAYS; w++) begin
            if (!query_valid[w] && !found) begin
                victim_way = WAY_W'(w);
                found      = 1'b1;
            end
        end
        if (!found) begin
            for (int w = 0; w < WAYS; w++) begin
                if (rank_q[query_set][w] == WAY_W'(WAYS - 1)) begin
                    victim_way = WAY_W'(w);
                end
            end
        end
    end

    logic             chk_en_q;
    logic [SET_W-1:0] chk_set_q;
    logic [WAY_W-1:0] chk_way_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chk_en_q  <= 1'b0;
            chk_set_q <= '0;
            chk_way_q <= '0;
        end else begin
            chk_en_q  <= touch_en;
            chk_set_q <= touch_set;
            chk_way_q <= touch_way;
        end
    end

    // R9
    mru_after_touch_chk: assert property (@(posedge clk) disable iff (rst)
        chk_en_q |-> (rank_q[chk_set_q][chk_way_q] == '0));

    for (genvar s = 0; s < SETS; s++) begin : g_perm
        logic [WAYS-1:0] seen;
        always_comb begin
            seen = '0;
            for (int w = 0; w < WAYS; w++) begin
                seen[rank_q[s][w]] = 1'b1;
            end
        end
        // R9
        rank_perm_chk: assert property (@(posedge clk) disable iff (rst)
            seen == {WAYS{1'b1}});
    end

endmodule

// File: rtl/cache_data_store.sv
module cache_data_store #(
    parameter int WAYS   = 4,
    parameter int SETS   = 16,
    parameter int WORDS  = 8,
    parameter int DATA_W = 32,
    localparam int WAY_W  = $clog2(WAYS),
    localparam int SET_W  = $clog2(SETS),
    localparam int WORD_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [WAY_W-1:0]  wr_way,
    input  logic [SET_W-1:0]  wr_set,
    input  logic [WORD_W-1:0] wr_word,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [SET_W-1:0]  rd_set,
    input  logic [WORD_W-1:0] rd_word,
    output logic [DATA_W-1:0] rd_data [WAYS]
);

    logic [DATA_W-1:0] store_q [WAYS][SETS][WORDS];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            store_q[wr_way][wr_set][wr_word] <= wr_data;
        end
    end

    for (genvar w = 0; w < WAYS; w++) begin : g_rd
        assign rd_data[w] = store_q[w][rd_set][rd_word];
    end

endmodule

// File: rtl/cache_wt4.sv
module cache_wt4
    import cache_wt_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int WAYS   = 4,
    parameter int SETS   = 16,
    parameter int WORDS  = 8,
    parameter int BANKS  = 4,
    localparam int OFF_W  = $clog2(DATA_W / 8),
    localparam int WORD_W = $clog2(WORDS),
    localparam int SET_W  = $clog2(SETS),
    localparam int WAY_W  = $clog2(WAYS),
    localparam int BANK_W = $clog2(BANKS),
    localparam int TAG_W  = ADDR_W - SET_W - WORD_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_ready,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BANK_W-1:0] mem_bank,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack
);

    cache_state_e state_q, state_d;

    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              we_q;
    logic [WORD_W-1:0] cnt_q;
    logic [WAY_W-1:0]  victim_q;

    logic [TAG_W-1:0]  tag_q   [WAYS][SETS];
    logic [WAYS-1:0]   valid_q [SETS];

    logic [TAG_W-1:0]  req_tag;
    logic [SET_W-1:0]  req_set;
    logic [WORD_W-1:0] req_word;
    logic [TAG_W-1:0]  cur_tag [WAYS];
    logic [WAYS-1:0]   cur_valid;
    logic [WAYS-1:0]   hit_vec;
    logic              hit;
    logic [WAY_W-1:0]  hit_way;
    logic [WAY_W-1:0]  victim_way;
    logic [DATA_W-1:0] way_rdata [WAYS];

    logic              fill_last;
    logic              ds_we;
    logic [WAY_W-1:0]  ds_way;
    logic [WORD_W-1:0] ds_word;
    logic [DATA_W-1:0] ds_data;
    logic              lru_touch;
    logic [WAY_W-1:0]  lru_way;

    assign req_tag   = addr_q[ADDR_W-1 -: TAG_W];
    assign req_set   = addr_q[OFF_W + WORD_W +: SET_W];
    assign req_word  = addr_q[OFF_W +: WORD_W];
    assign fill_last = (state_q == ST_FILL) && mem_ack && (cnt_q == WORD_W'(WORDS - 1));

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign cur_tag[w]   = tag_q[w][req_set];
        assign cur_valid[w] = valid_q[req_set][w];
    end

    cache_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
        .clk       (clk),
        .rst       (rst),
        .cmp_en    (state_q == ST_TAG),
        .way_tag   (cur_tag),
        .way_valid (cur_valid),
        .req_tag   (req_tag),
        .hit_vec   (hit_vec),
        .hit       (hit),
        .hit_way   (hit_way)
    );

    cache_lru #(.WAYS(WAYS), .SETS(SETS)) u_lru (
        .clk         (clk),
        .rst         (rst),
        .touch_en    (lru_touch),
        .touch_set   (req_set),
        .touch_way   (lru_way),
        .query_set   (req_set),
        .query_valid (cur_valid),
        .victim_way  (victim_way)
    );

    cache_data_store #(.WAYS(WAYS), .SETS(SETS), .WORDS(WORDS), .DATA_W(DATA_W)) u_data (
        .clk     (clk),
        .wr_en   (ds_we),
        .wr_way  (ds_way),
        .wr_set  (req_set),
        .wr_word (ds_word),
        .wr_data (ds_data),
        .rd_set  (req_set),
        .rd_word (req_word),
        .rd_data (way_rdata)
    );

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (cpu_req) state_d = ST_TAG;
            ST_TAG: begin
                if (we_q)     state_d = ST_WRITE;
                else if (hit) state_d = ST_IDLE;
                else          state_d = ST_FILL;
            end
            ST_FILL:  if (fill_last) state_d = ST_DONE;
            ST_WRITE: if (mem_ack) state_d = ST_IDLE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register and request capture
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            addr_q   <= '0;
            wdata_q  <= '0;
            we_q     <= 1'b0;
            cnt_q    <= '0;
            victim_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && cpu_req) begin
                addr_q  <= cpu_addr;
                wdata_q <= cpu_wdata;
                we_q    <= cpu_we;
            end
            if (state_q == ST_TAG) begin
                victim_q <= victim_way;
                cnt_q    <= '0;
            end else if (state_q == ST_FILL && mem_ack) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // tag and valid arrays
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= '0;
            end
        end else if (state_q == ST_TAG && !we_q && !hit) begin
            valid_q[req_set][victim_way] <= 1'b0;
        end else if (fill_last) begin
            valid_q[req_set][victim_q] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_last) begin
            tag_q[victim_q][req_set] <= req_tag;
        end
    end

    // outputs and array controls
    always_comb begin
        cpu_ready = 1'b0;
        cpu_rdata = way_rdata[hit_way];
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = {addr_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
        mem_wdata = wdata_q;
        ds_we     = 1'b0;
        ds_way    = hit_way;
        ds_word   = req_word;
        ds_data   = wdata_q;
        lru_touch = 1'b0;
        lru_way   = hit_way;
        unique case (state_q)
            ST_IDLE: ;
            ST_TAG: begin
                cpu_ready = !we_q && hit;
                ds_we     = we_q && hit;
                lru_touch = hit;
            end
            ST_FILL: begin
                mem_req   = 1'b1;
                mem_addr  = {req_tag, req_set, cnt_q, {OFF_W{1'b0}}};
                ds_we     = mem_ack;
                ds_way    = victim_q;
                ds_word   = cnt_q;
                ds_data   = mem_rdata;
                lru_touch = fill_last;
                lru_way   = victim_q;
            end
            ST_WRITE: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                cpu_ready = mem_ack;
            end
            ST_DONE: begin
                cpu_ready = 1'b1;
                cpu_rdata = way_rdata[victim_q];
            end
            default: ;
        endcase
    end

    assign mem_bank = mem_addr[OFF_W +: BANK_W];

    logic any_valid;
    always_comb begin
        any_valid = 1'b0;
        for (int s = 0; s < SETS; s++) begin
            any_valid = any_valid | (|valid_q[s]);
        end
    end

    // R1
    rst_clears_valid_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !any_valid);

    // R3
    fill_step_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_FILL && mem_ack && !fill_last) |=>
        (mem_addr[OFF_W +: WORD_W] == WORD_W'($past(mem_addr[OFF_W +: WORD_W]) + 1'b1)));

    // R3
    fill_bank_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we) |-> (mem_bank == cnt_q[BANK_W-1:0]));

    // R5
    wr_stall_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_ready && we_q) |-> (mem_ack && mem_we));

    // R8
    fill_invalid_first_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_TAG && !we_q && !hit && !(&cur_valid)) |-> !cur_valid[victim_way]);

endmodule

// File: tb/cache_wt4_bench.sv
module cache_wt4_bench;

    localparam int CLK_PERIOD = 10;
    localparam int MEM_WORDS  = 4096;
    localparam int MISS_LAT   = 18;
    localparam int HIT_LAT    = 1;
    localparam int WR_LAT     = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_req = 1'b0;
    logic        cpu_we = 1'b0;
    logic [31:0] cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic        cpu_ready;
    logic        mem_req;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [1:0]  mem_bank;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;

    int checks = 0;
    int fails  = 0;

    logic [31:0] mem_arr [MEM_WORDS];
    logic [31:0] shadow  [MEM_WORDS];
    logic [31:0] fill_addr_log [32];
    logic [1:0]  fill_bank_log [32];
    int          fill_n = 0;
    int          wr_n   = 0;
    logic [31:0] last_wr_addr = '0;
    logic [31:0] last_wr_data = '0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    cache_wt4 u_cache_wt4 (
        .clk       (clk),
        .rst       (rst),
        .cpu_req   (cpu_req),
        .cpu_we    (cpu_we),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .cpu_rdata (cpu_rdata),
        .cpu_ready (cpu_ready),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_bank  (mem_bank),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_ack   (mem_ack)
    );

    function automatic logic [31:0] seed_word(int idx);
        return (idx * 32'h9E37_79B1) ^ 32'h5A5A_0000;
    endfunction

    // main memory model: acknowledges one cycle after a request appears
    always @(posedge clk) begin
        mem_ack <= mem_req && !mem_ack;
        if (mem_req && !mem_ack) begin
            mem_rdata <= mem_arr[mem_addr[13:2]];
            if (mem_we) begin
                mem_arr[mem_addr[13:2]] <= mem_wdata;
                wr_n         <= wr_n + 1;
                last_wr_addr <= mem_addr;
                last_wr_data <= mem_wdata;
            end else if (fill_n < 32) begin
                fill_addr_log[fill_n] <= mem_addr;
                fill_bank_log[fill_n] <= mem_bank;
                fill_n <= fill_n + 1;
            end
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_addr(int tag, int set, int word);
        return (32'(tag) << 9) | (32'(set) << 5) | (32'(word) << 2);
    endfunction

    task automatic access(input bit we, input logic [31:0] a, input logic [31:0] d,
                          output logic [31:0] rd, output int lat);
        @(negedge clk);
        cpu_req   = 1'b1;
        cpu_we    = we;
        cpu_addr  = a;
        cpu_wdata = d;
        lat = 0;
        do begin
            @(posedge clk);
            lat++;
            @(negedge clk);
        end while (!cpu_ready && lat < 200);
        rd = cpu_rdata;
        cpu_req = 1'b0;
        if (we) shadow[a[13:2]] = d;
    endtask

    task automatic read_expect(input logic [31:0] a, input int exp_lat, input string req);
        logic [31:0] rd;
        int lat;
        access(1'b0, a, 32'h0, rd, lat);
        check(lat == exp_lat, {req, " latency"}, 32'(lat), 32'(exp_lat));
        check(rd == shadow[a[13:2]], {req, " data"}, rd, shadow[a[13:2]]);
    endtask

    // R1 and R3: cold miss after reset, refill order and banks
    task automatic t_reset_and_fill;
        int base;
        check(cpu_ready == 1'b0, "R1 ready low after reset", 32'(cpu_ready), 32'h0);
        check(mem_req == 1'b0, "R1 no memory request after reset", 32'(mem_req), 32'h0);
        base = fill_n;
        read_expect(mk_addr(2, 0, 5), MISS_LAT, "R1 cold read miss");
        check(fill_n - base == 8, "R3 eight words fetched", 32'(fill_n - base), 32'd8);
        for (int i = 0; i < 8; i++) begin
            check(fill_addr_log[base + i] == mk_addr(2, 0, i), "R3 fill order",
                  fill_addr_log[base + i], mk_addr(2, 0, i));
            check(fill_bank_log[base + i] == 2'(i % 4), "R3 fill bank",
                  32'(fill_bank_log[base + i]), 32'(i % 4));
        end
    endtask

    // R2 and R4: other word of the resident block
    task automatic t_read_hit;
        read_expect(mk_addr(2, 0, 1), HIT_LAT, "R2 read hit");
        read_expect(mk_addr(2, 0, 5), HIT_LAT, "R4 word select hit");
    endtask

    // R5 and R6: store hit
    task automatic t_write_hit;
        logic [31:0] rd;
        int lat;
        int w0;
        w0 = wr_n;
        access(1'b1, mk_addr(2, 0, 3), 32'hCAFE_0103, rd, lat);
        check(lat == WR_LAT, "R5 store latency", 32'(lat), 32'(WR_LAT));
        @(negedge clk);
        check(wr_n - w0 == 1, "R5 one memory write", 32'(wr_n - w0), 32'd1);
        check(last_wr_addr == mk_addr(2, 0, 3), "R5 write address", last_wr_addr, mk_addr(2, 0, 3));
        check(last_wr_data == 32'hCAFE_0103, "R5 write data", last_wr_data, 32'hCAFE_0103);
        read_expect(mk_addr(2, 0, 3), HIT_LAT, "R6 updated word hit");
    endtask

    // R5 and R7: store miss
    task automatic t_write_miss;
        logic [31:0] rd;
        int lat;
        int w0;
        w0 = wr_n;
        access(1'b1, mk_addr(7, 9, 6), 32'hBEEF_0796, rd, lat);
        @(negedge clk);
        check(wr_n - w0 == 1, "R5 write-miss memory write", 32'(wr_n - w0), 32'd1);
        check(last_wr_data == 32'hBEEF_0796, "R5 write-miss data", last_wr_data, 32'hBEEF_0796);
        read_expect(mk_addr(7, 9, 6), MISS_LAT, "R7 no allocate on store miss");
    endtask

    // R8 and R9: fill one set, then evict by LRU
    task automatic t_ways_and_lru;
        for (int t = 1; t <= 4; t++) read_expect(mk_addr(t, 3, 0), MISS_LAT, "R8 fill set");
        for (int t = 1; t <= 4; t++) read_expect(mk_addr(t, 3, 2), HIT_LAT, "R8 four ways resident");
        // recency now 4,3,2,1 (oldest last); touch tag 1 so tag 2 is oldest
        read_expect(mk_addr(1, 3, 4), HIT_LAT, "R9 touch");
        read_expect(mk_addr(5, 3, 0), MISS_LAT, "R9 fifth tag miss");
        read_expect(mk_addr(1, 3, 0), HIT_LAT, "R9 recent kept 1");
        read_expect(mk_addr(3, 3, 0), HIT_LAT, "R9 recent kept 3");
        read_expect(mk_addr(4, 3, 0), HIT_LAT, "R9 recent kept 4");
        // tag 2 was the victim; its reload evicts tag 5 (now oldest)
        read_expect(mk_addr(2, 3, 0), MISS_LAT, "R9 oldest evicted");
        read_expect(mk_addr(5, 3, 1), MISS_LAT, "R9 second eviction order");
        read_expect(mk_addr(2, 0, 1), HIT_LAT, "R4 other set untouched");
    endtask

    initial begin
        for (int i = 0; i < MEM_WORDS; i++) begin
            mem_arr[i] = seed_word(i);
            shadow[i]  = seed_word(i);
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset_and_fill();
        t_read_hit();
        t_write_hit();
        t_write_miss();
        t_ways_and_lru();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog: run did not complete actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule